// File: doc/BRIEF.md
# Fine-adjusted PWM DAC

This block turns a 14-bit code into a pulse-width waveform that an external low-pass filter averages into an analog level. A 14-bit counter advances on every enabled clock, one step per resolution period, and a frame lasts 16384 periods. The frame is cut into equal base cycles. Each base cycle opens with a coarse high pulse. The fractional part of the code then lengthens some base cycles by exactly one period, so the high time over a whole frame equals the code.

The base cycle length comes from a carrier select bit. A long base cycle is 256 periods and takes the upper 8 code bits as the coarse width, with the lower 6 bits as the fine count across 64 base cycles. A short base cycle is 64 periods, with 6 coarse bits and 8 fine bits across 256 base cycles. The stretched base cycles are picked by comparing the fine count against a bit-reversed base-cycle index. This spreads them evenly over the frame. Software writes the code and the carrier select in a single 16-bit register. The running compare copy is reloaded only between frames. A code outside the range allowed for the selected carrier keeps the output low.

Top module: `finepwm_dac`

## Requirements
- R1: After reset, `rd_data` reads 0xFFFF and `pwm_out` is low.
- R2: A write with `wr_en` and `wr_full` both high stores `wr_data[15:1]`. Bits 15..2 are the code and bit 1 is the carrier select (1 = 256-period base cycle, 0 = 64-period base cycle). Bit 0 always reads 1.
- R3: A write with `wr_en` high and `wr_full` low, which marks a byte-wide access, leaves the register and `rd_data` unchanged.
- R4: With carrier select 1, every base cycle of 256 periods is high from its first period for either `code[13:6]` or `code[13:6]`+1 periods. Exactly `code[5:0]` base cycles get the extra period, so a frame holds `code` high periods.
- R5: With carrier select 0, every base cycle of 64 periods is high from its first period for either `code[13:8]` or `code[13:8]`+1 periods. Exactly `code[7:0]` base cycles get the extra period, so a frame holds `code` high periods.
- R6: The stretched base cycles are spread out. The first half of a frame holds ceil(fine/2) of them.
- R7: A register write takes effect at the start of the next frame. A frame that is already running keeps the value it started with.
- R8: The 16-bit register value (bit 0 = 1) must lie in 0x0401..0xFFFD when carrier select is 0, or in 0x0103..0xFFFF when it is 1. Outside that range, `pwm_out` stays low for the whole frame.
- R9: While `en` is low, `pwm_out` is low and the counter is held at zero. The first frame begins on the first clock edge where `en` is sampled high, and `pwm_out` reflects count k one cycle after that count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one resolution unit |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable for counter and output |
| wr_en | input | 1 | Register write strobe |
| wr_full | input | 1 | 1 = full 16-bit access, 0 = byte access (ignored) |
| wr_data | input | 16 | Write data: code[13:0], carrier select, reserved |
| rd_data | output | 16 | Register read-back, bit 0 fixed at 1 |
| pwm_out | output | 1 | Pulse-width modulated output |

## Verification
The assertions assume that `wr_full` only matters while `wr_en` is high. They also assume that reset is held for at least one clock before any property is sampled, so every `$past` term refers to a cycle after reset. The stimulus writes only at the middle of a frame, so a reload can never coincide with a write. It changes `en` only between complete measured frames, so each frame the scoreboard measures starts from a counter value of zero.

// File: rtl/finepwm_pkg.sv
package finepwm_pkg;

  localparam int CNT_W = 14;
  localparam int REG_W = CNT_W + 2;
  localparam int POS_S = 6;
  localparam int POS_L = 8;
  localparam int IDX_S = CNT_W - POS_S;
  localparam int IDX_L = CNT_W - POS_L;

  localparam logic [REG_W:0] LO_SHORT = 17'h00401;
  localparam logic [REG_W:0] HI_SHORT = 17'h0FFFD;
  localparam logic [REG_W:0] LO_LONG  = 17'h00103;
  localparam logic [REG_W:0] HI_LONG  = 17'h0FFFF;

  typedef struct packed {
    logic [CNT_W-1:0] val;
    logic             car;
  } cfg_t;

  function automatic logic [IDX_S-1:0] rev_s(input logic [IDX_S-1:0] v);
    logic [IDX_S-1:0] r;
    for (int i = 0; i < IDX_S; i++) r[i] = v[IDX_S-1-i];
    return r;
  endfunction

  function automatic logic [IDX_L-1:0] rev_l(input logic [IDX_L-1:0] v);
    logic [IDX_L-1:0] r;
    for (int i = 0; i < IDX_L; i++) r[i] = v[IDX_L-1-i];
    return r;
  endfunction

  function automatic logic in_range(input cfg_t k);
    logic [REG_W:0] s;
    s = {1'b0, k.val, k.car, 1'b1};
    if (k.car) return (s >= LO_LONG) && (s <= HI_LONG);
    return (s >= LO_SHORT) && (s <= HI_SHORT);
  endfunction

  function automatic logic [POS_L-1:0] base_pos(input logic car, input logic [CNT_W-1:0] c);
    return car ? c[POS_L-1:0] : POS_L'(c[POS_S-1:0]);
  endfunction

  function automatic logic [IDX_S-1:0] slot_rank(input logic car, input logic [CNT_W-1:0] c);
    return car ? IDX_S'(rev_l(c[CNT_W-1:POS_L])) : rev_s(c[CNT_W-1:POS_S]);
  endfunction

  function automatic logic [POS_L-1:0] coarse_of(input cfg_t k);
    return k.car ? k.val[CNT_W-1 -: POS_L] : POS_L'(k.val[CNT_W-1 -: POS_S]);
  endfunction

  function automatic logic [IDX_S-1:0] fine_of(input cfg_t k);
    return k.car ? IDX_S'(k.val[IDX_L-1:0]) : k.val[IDX_S-1:0];
  endfunction

endpackage

// File: rtl/finepwm_regs.sv
module finepwm_regs
  import finepwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_full,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output cfg_t             cfg
);

  logic [REG_W-1:1] shadow;
  logic             wide_write;

  assign wide_write = wr_en && wr_full;

  always_ff @(posedge clk) begin
    if (!rst_n)          shadow <= '1;
    else if (wide_write) shadow <= wr_data[REG_W-1:1];
  end

  assign rd_data = {shadow, 1'b1};
  assign cfg     = cfg_t'(shadow);

  AST_WIDE_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_full) |=> (rd_data[REG_W-1:1] == $past(wr_data[REG_W-1:1]))); // R2

  AST_BYTE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_full) |=> $stable(rd_data)); // R3

endmodule

// File: rtl/finepwm_cnt.sv
module finepwm_cnt
  import finepwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [CNT_W-1:0] cnt,
  output logic             frame_end
);

  localparam logic [CNT_W-1:0] LAST = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (!en) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end

  assign frame_end = en && (cnt == LAST);

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (cnt == '0)); // R9

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0)); // R9

endmodule

// File: rtl/finepwm_cmp.sv
module finepwm_cmp
  import finepwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             frame_end,
  input  logic [CNT_W-1:0] cnt,
  input  cfg_t             cfg_in,
  output logic             pwm_out
);

  cfg_t             active;
  logic             reload;
  logic             valid;
  logic [POS_L-1:0] pos;
  logic [POS_L-1:0] coarse;
  logic [IDX_S-1:0] fine;
  logic [IDX_S-1:0] rank;
  logic             body_on;
  logic             stretch_on;

  assign reload = !en || frame_end;

  always_ff @(posedge clk) begin
    if (!rst_n)      active <= '1;
    else if (reload) active <= cfg_in;
  end

  assign valid      = in_range(active);
  assign pos        = base_pos(active.car, cnt);
  assign rank       = slot_rank(active.car, cnt);
  assign coarse     = coarse_of(active);
  assign fine       = fine_of(active);
  assign body_on    = pos < coarse;
  assign stretch_on = (pos == coarse) && (fine > rank);

  always_ff @(posedge clk) begin
    if (!rst_n) pwm_out <= 1'b0;
    else        pwm_out <= en && valid && (body_on || stretch_on);
  end

  AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !frame_end) |=> $stable(active)); // R7

  AST_QUIET_WHEN_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || !valid) |=> !pwm_out); // R8

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({body_on, stretch_on})); // R4

endmodule

// File: rtl/finepwm_dac.sv
module finepwm_dac
  import finepwm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        wr_en,
  input  logic        wr_full,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  output logic        pwm_out
);

  cfg_t             cfg;
  logic [CNT_W-1:0] cnt;
  logic             frame_end;

  finepwm_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_full (wr_full),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .cfg     (cfg)
  );

  finepwm_cnt u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .cnt       (cnt),
    .frame_end (frame_end)
  );

  finepwm_cmp u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .frame_end (frame_end),
    .cnt       (cnt),
    .cfg_in    (cfg),
    .pwm_out   (pwm_out)
  );

endmodule

// File: tb/finepwm_dac_tb.sv
module finepwm_dac_tb;

  logic        clk = 1'b0;
  logic        rst_n, en, wr_en, wr_full;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic        pwm_out;

  always #10 clk = ~clk;

  finepwm_dac u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_full(wr_full),
    .wr_data(wr_data), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  localparam int FRAME = 16384;
  localparam int NFR   = 9;

  int          checks = 0;
  int          errors = 0;
  bit          mon_done = 0;
  bit          finished = 0;
  logic [15:0] expq[$];
  event        go, mid;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [15:0] v, input bit full);
    @(negedge clk);
    wr_en = 1'b1; wr_full = full; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0; wr_full = 1'b0;
  endtask

  // Monitor: measures each frame and compares it with the queued item
  initial begin
    @go;
    for (int f = 0; f < NFR; f++) begin
      logic [15:0] s;
      bit cs, ok_range, shape_bad;
      int d, n, nb, coarse, fine, total, stretched, first_half, exp_total;
      string req;
      if (expq.size() == 0) begin
        check(1'b0, "R7", "scoreboard empty", 0, 1);
        s = 16'h0001;
      end else s = expq.pop_front();
      cs = s[1];
      d  = int'(s[15:2]);
      ok_range = cs ? (s >= 16'h0103) : (s >= 16'h0401 && s <= 16'hFFFD);
      n      = cs ? 256 : 64;
      nb     = FRAME / n;
      coarse = d / nb;
      fine   = d % nb;
      total = 0; stretched = 0; first_half = 0; shape_bad = 0;
      for (int b = 0; b < nb; b++) begin
        int h; bit low_seen;
        h = 0; low_seen = 0;
        for (int p = 0; p < n; p++) begin
          @(negedge clk);
          if (b * n + p == 8000) -> mid;
          if (pwm_out) begin
            if (low_seen) shape_bad = 1;
            h++;
          end else low_seen = 1;
        end
        total += h;
        if (ok_range) begin
          if (h == coarse + 1) begin
            stretched++;
            if (b < nb / 2) first_half++;
          end else if (h != coarse) shape_bad = 1;
        end
      end
      req = !ok_range ? "R8" : (cs ? "R4" : "R5");
      exp_total = ok_range ? d : 0;
      // frame total also shows R7: the value was written mid-way through the previous frame
      check(total == exp_total, req, $sformatf("frame %0d high total (R7)", f), total, exp_total);
      check(!shape_bad, req, $sformatf("frame %0d base-cycle shape", f), int'(shape_bad), 0);
      if (ok_range) begin
        check(stretched == fine, req, $sformatf("frame %0d stretched count", f), stretched, fine);
        check(first_half == (fine + 1) / 2, "R6", $sformatf("frame %0d first-half stretch", f),
              first_half, (fine + 1) / 2);
      end
    end
    mon_done = 1;
  end

  // Driver: writes one value per frame, mid-frame, and pushes it
  initial begin
    logic [15:0] vals[8];
    vals = '{16'h5A47, 16'h2AB5, 16'h0103, 16'h00FF,
             16'h0401, 16'h03FD, 16'hFFFD, 16'h8201};
    rst_n = 1'b0; en = 1'b0; wr_en = 1'b0; wr_full = 1'b0; wr_data = '0;
    repeat (4) @(negedge clk);
    check(pwm_out == 1'b0, "R1", "pwm_out in reset", int'(pwm_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_data == 16'hFFFF, "R1", "rd_data after reset", int'(rd_data), 16'hFFFF);
    check(pwm_out == 1'b0, "R1", "pwm_out after reset", int'(pwm_out), 0);
    expq.push_back(16'hFFFF);
    en = 1'b1;
    -> go;
    for (int i = 0; i < 8; i++) begin
      @mid;
      if (i == 0) begin
        reg_write(16'h5A46, 1'b1);
        check(rd_data == 16'h5A47, "R2", "bit0 forced on readback", int'(rd_data), 16'h5A47);
      end else reg_write(vals[i], 1'b1);
      if (i == 3) begin
        reg_write(16'h5A46, 1'b0);
        check(rd_data == 16'h00FF, "R3", "byte write ignored", int'(rd_data), 16'h00FF);
      end
      expq.push_back(vals[i]);
    end
    wait (mon_done);
    @(negedge clk);
    en = 1'b0;
    begin
      int highs;
      highs = 0;
      @(negedge clk);
      for (int k = 0; k < 300; k++) begin
        if (pwm_out) highs++;
        @(negedge clk);
      end
      check(highs == 0, "R9", "output while disabled", highs, 0);
    end
    check(rd_data == 16'h8201, "R2", "register kept while disabled", int'(rd_data), 16'h8201);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule